// File: doc/BRIEF.md
# Slow-Clock System Timer

This peripheral keeps time from a slow-clock tick. The tick reaches the block as a one-cycle enable that is synchronous to the bus clock. A real-time counter advances once every programmable number of ticks and wraps to zero. A periodic interval unit raises an event at a fixed rate. An alarm compares the counter against an absolute target and fires when the counter steps onto it. The alarm has no relative mode. Because it fires only on equality, loading the current count does not fire at once: the match comes one full counter wrap later.

Each of the three units feeds its own bit in a status word. Reading the status word clears it. A mask is set and cleared through separate write-only registers, and one interrupt line reports any pending bit whose mask bit is set. A status bit is reserved for a watchdog overflow. No watchdog is built, so that bit always reads zero.

Software reaches the block through a plain synchronous register port inside a 256-byte window. Word registers are selected by `addr[7:2]`. A write takes effect on the clock edge where `wr_en` is high. Read data is registered and appears on `rdata` the cycle after `rd_en`, then holds until the next read. The port has no back-pressure: every access completes in one cycle.

Top module: `slow_sys_timer`

## Requirements
- R1: The real-time counter is `CNT_W` bits wide (default 20). It adds one on each prescaled increment and wraps from all-ones to zero. Its value reads at offset 0x24, and writes to 0x24 have no effect.
- R2: The prescaler is bits [15:0] at offset 0x0C and resets to 0x8000. The counter advances on every P-th tick, and P=0 counts as 65536. Writing the prescaler clears both the counter and the prescale phase.
- R3: The alarm target is at offset 0x20 and resets to all-ones. Status bit 3 sets on the cycle after the counter steps to a value equal to the target. Loading the value the counter already holds produces no match until the counter has made a full wrap.
- R4: Offset 0x04 bits [15:0] hold the interval P. A write restarts the interval. Status bit 0 then sets on the P-th tick after the write and on every P ticks after that. P=0 produces no periodic events.
- R5: The status word is at offset 0x10. Bit 0 is the periodic event, bit 1 is watchdog overflow (always 0), bit 2 is counter increment and bit 3 is alarm. A read returns the pending bits and clears them.
- R6: A 1 written to offset 0x14 sets the matching mask bit, and a 1 written to offset 0x18 clears it. Bits written as 0 leave the mask unchanged. The mask reads at offset 0x1C.
- R7: `irq` is high exactly while some status bit is both pending and unmasked.
- R8: An event that arrives in the same cycle as a status read is not returned by that read and stays pending afterwards.
- R9: Addresses with no register read as zero. Read data appears on `rdata` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle slow-clock tick enable |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address in the 256-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, OR of enabled pending events |

## Verification
The bench steers the counter to the alarm target from both sides. The target is first set ahead of the count and then set equal to it. A comparator that also fired on the existing value, or that compared against the relative distance, would raise bit 3 at once instead of one wrap later. To keep a wrap within reach, the bench runs the counter narrowed to 12 bits. It times the prescaler at the reset value, at 3 and at the value 0. A decoder that read 0 as zero ticks, or that failed to clear the phase on a write, would return the wrong count. It also issues a status read in the same cycle as a periodic event: a design that cleared unconditionally would lose that event. Finally it checks that 0 bits written to the mask registers leave the other mask bits untouched.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NUM_EV = 4;

  // event bit positions in the status word
  localparam int EV_PIT = 0;
  localparam int EV_WDG = 1;
  localparam int EV_RTI = 2;
  localparam int EV_ALM = 3;

  // word index = addr[7:2]
  typedef enum logic [5:0] {
    RX_PIT = 6'h01,
    RX_RTM = 6'h03,
    RX_STS = 6'h04,
    RX_IEN = 6'h05,
    RX_IDS = 6'h06,
    RX_IMK = 6'h07,
    RX_ALM = 6'h08,
    RX_CNT = 6'h09
  } reg_idx_e;
endpackage

// File: rtl/stm_rtt.sv
module stm_rtt #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cfg_wr,
  input  logic [PRE_W-1:0] cfg_val,
  output logic [PRE_W-1:0] presc_o,
  output logic [CNT_W-1:0] count_o,
  output logic             inc_o
);
  localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [PRE_W-1:0] PRE_INIT = PRE_W'(PRE_RST);

  logic [PRE_W-1:0] presc_q, phase_q, last_phase;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  // value 0 wraps to all-ones here: a full 2^PRE_W tick period
  assign last_phase = presc_q - PRE_ONE;
  assign at_last    = (phase_q == last_phase);
  assign inc_o      = tick_en && !cfg_wr && at_last;
  assign presc_o    = presc_q;
  assign count_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= PRE_INIT;
      phase_q <= '0;
      cnt_q   <= '0;
    end else if (cfg_wr) begin
      presc_q <= cfg_val;
      phase_q <= '0;
      cnt_q   <= '0;
    end else if (tick_en) begin
      phase_q <= at_last ? '0 : phase_q + PRE_ONE;
      if (at_last) cnt_q <= cnt_q + CNT_ONE;
    end
  end

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_ONE)));
  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_o && !cfg_wr) |=> $stable(cnt_q));
  p_cfg_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cnt_q == '0 && phase_q == '0));
endmodule

// File: rtl/stm_alarm.sv
module stm_alarm #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alm_wr,
  input  logic [CNT_W-1:0] alm_val,
  input  logic             inc,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] target_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] target_q, next_cnt;

  // match on the value the counter is about to take, so a target equal
  // to the present count waits for a full wrap
  assign next_cnt = count + CNT_ONE;
  assign hit_o    = inc && (next_cnt == target_q);
  assign target_o = target_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      target_q <= '1;
    else if (alm_wr) target_q <= alm_val;
  end

  p_no_hit_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |-> !hit_o);
endmodule

// File: rtl/stm_pit.sv
module stm_pit #(
  parameter int PIT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load,
  input  logic [PIT_W-1:0] load_val,
  output logic [PIT_W-1:0] period_o,
  output logic             evt_o
);
  localparam logic [PIT_W-1:0] PIT_ONE = PIT_W'(1);

  logic [PIT_W-1:0] per_q, left_q;

  assign evt_o    = tick_en && !load && (left_q == PIT_ONE);
  assign period_o = per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      per_q  <= load_val;
      left_q <= load_val;
    end else if (tick_en && per_q != '0) begin
      left_q <= (left_q == PIT_ONE) ? per_q : left_q - PIT_ONE;
    end
  end

  p_pit_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0) |-> !evt_o);
  p_pit_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> (left_q == $past(per_q)));
endmodule

// File: rtl/stm_evt.sv
module stm_evt #(
  parameter int NEV = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt,
  input  logic           sts_rd,
  input  logic           ien_wr,
  input  logic           ids_wr,
  input  logic [NEV-1:0] wbits,
  output logic [NEV-1:0] status_o,
  output logic [NEV-1:0] mask_o,
  output logic           irq_o
);
  logic [NEV-1:0] sts_q, msk_q, set_m, clr_m;

  assign set_m    = ien_wr ? wbits : '0;
  assign clr_m    = ids_wr ? wbits : '0;
  assign status_o = sts_q;
  assign mask_o   = msk_q;
  assign irq_o    = |(sts_q & msk_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '0;
    end else begin
      sts_q <= sts_rd ? evt : (sts_q | evt);
      msk_q <= (msk_q | set_m) & ~clr_m;
    end
  end

  p_rdclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && evt == '0) |=> (sts_q == '0));
  p_keep_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd |=> ((sts_q & $past(evt)) == $past(evt)));
  p_ien_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ien_wr |=> ((msk_q & $past(wbits)) == $past(wbits)));
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_wr && !ids_wr) |=> $stable(msk_q));
endmodule

// File: rtl/slow_sys_timer.sv
module slow_sys_timer
  import stm_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PIT_W   = 16,
  parameter int PRE_RST = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [5:0]        widx;
  logic              wr_pit, wr_rtm, wr_ien, wr_ids, wr_alm, rd_sts;
  logic [PRE_W-1:0]  presc;
  logic [CNT_W-1:0]  count, target;
  logic [PIT_W-1:0]  period;
  logic              inc, alm_hit, pit_evt;
  logic [NUM_EV-1:0] evt, status, mask;
  logic [DATA_W-1:0] rmux, rdata_q;

  assign widx   = addr[7:2];
  assign wr_pit = wr_en && widx == RX_PIT;
  assign wr_rtm = wr_en && widx == RX_RTM;
  assign wr_ien = wr_en && widx == RX_IEN;
  assign wr_ids = wr_en && widx == RX_IDS;
  assign wr_alm = wr_en && widx == RX_ALM;
  assign rd_sts = rd_en && widx == RX_STS;

  stm_rtt #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_wr(wr_rtm),
    .cfg_val(wdata[PRE_W-1:0]), .presc_o(presc), .count_o(count), .inc_o(inc)
  );

  stm_alarm #(.CNT_W(CNT_W)) u_alm (
    .clk(clk), .rst_n(rst_n), .alm_wr(wr_alm), .alm_val(wdata[CNT_W-1:0]),
    .inc(inc), .count(count), .target_o(target), .hit_o(alm_hit)
  );

  stm_pit #(.PIT_W(PIT_W)) u_pit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(wr_pit),
    .load_val(wdata[PIT_W-1:0]), .period_o(period), .evt_o(pit_evt)
  );

  always_comb begin
    evt         = '0;
    evt[EV_PIT] = pit_evt;
    evt[EV_WDG] = 1'b0;
    evt[EV_RTI] = inc;
    evt[EV_ALM] = alm_hit;
  end

  stm_evt #(.NEV(NUM_EV)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sts_rd(rd_sts),
    .ien_wr(wr_ien), .ids_wr(wr_ids), .wbits(wdata[NUM_EV-1:0]),
    .status_o(status), .mask_o(mask), .irq_o(irq)
  );

  always_comb begin
    rmux = '0;
    case (widx)
      RX_PIT:  rmux = DATA_W'(period);
      RX_RTM:  rmux = DATA_W'(presc);
      RX_STS:  rmux = DATA_W'(status);
      RX_IMK:  rmux = DATA_W'(mask);
      RX_ALM:  rmux = DATA_W'(target);
      RX_CNT:  rmux = DATA_W'(count);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rmux;
  end
  assign rdata = rdata_q;

  p_alarm_abs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[EV_ALM]) && !$past(wr_alm)) |-> (count == target));
  p_wdg_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !status[EV_WDG]);
  p_irq_needs_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: tb/sim_slow_sys_timer.sv
module sim_slow_sys_timer;
  localparam int CW = 12;
  localparam logic [7:0] A_PIT = 8'h04, A_RTM = 8'h0C, A_STS = 8'h10,
    A_IEN = 8'h14, A_IDS = 8'h18, A_IMK = 8'h1C, A_ALM = 8'h20,
    A_CNT = 8'h24, A_NONE = 8'h08;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  slow_sys_timer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data against the scoreboard queue
  initial forever begin
    @(posedge clk);
    if (rd_en) begin
      @(negedge clk);
      if (exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(A_STS, 32'h0, "R5 reset status");
    rd(A_IMK, 32'h0, "R6 reset mask");
    rd(A_CNT, 32'h0, "R1 reset count");
    rd(A_RTM, 32'h8000, "R2 reset prescaler");
    rd(A_ALM, 32'hFFF, "R3 reset alarm");
    rd(A_NONE, 32'h0, "R9 unused address");
    check("R7 reset irq", {31'h0, irq}, 32'h0);
    // default prescaler: one step per 32768 ticks
    ticks(32767);
    rd(A_CNT, 32'h0, "R2 default prescale before step");
    rd(A_STS, 32'h0, "R5 no increment yet");
    ticks(1);
    rd(A_CNT, 32'h1, "R2 default prescale step");
    rd(A_STS, 32'h4, "R5 increment flag");
    rd(A_STS, 32'h0, "R5 read cleared");
    // prescaler 3
    wr(A_RTM, 32'h3);
    rd(A_CNT, 32'h0, "R2 write clears counter");
    ticks(7);
    rd(A_CNT, 32'h2, "R2 prescale 3");
    rd(A_RTM, 32'h3, "R2 prescaler readback");
    // prescaler 0 -> 65536
    wr(A_RTM, 32'h0);
    ticks(65535);
    rd(A_CNT, 32'h0, "R2 zero prescale before step");
    ticks(1);
    rd(A_CNT, 32'h1, "R2 zero prescale step");
    rd(A_STS, 32'h4, "R5 status clear");
    // alarm ahead of count
    wr(A_RTM, 32'h1);
    wr(A_ALM, 32'd10);
    ticks(9);
    rd(A_STS, 32'h4, "R3 no alarm before target");
    ticks(1);
    rd(A_STS, 32'hC, "R3 alarm at target");
    // alarm equal to current count waits a full wrap
    wr(A_ALM, 32'd10);
    ticks(100);
    rd(A_STS, 32'h4, "R3 equal target no immediate match");
    ticks(3995);
    rd(A_CNT, 32'd9, "R1 counter wrapped");
    rd(A_STS, 32'h4, "R3 no match one before wrap");
    ticks(1);
    rd(A_STS, 32'hC, "R3 match after wrap");
    // count register is read-only
    wr(A_CNT, 32'h123);
    rd(A_CNT, 32'd10, "R1 count write ignored");
    // periodic unit
    wr(A_RTM, 32'h8000);
    rd(A_STS, 32'h0, "R5 quiet");
    wr(A_PIT, 32'd4);
    ticks(3);
    rd(A_STS, 32'h0, "R4 before period");
    ticks(1);
    rd(A_STS, 32'h1, "R4 first period");
    ticks(4);
    rd(A_STS, 32'h1, "R4 repeats");
    ticks(2);
    wr(A_PIT, 32'd4);
    ticks(3);
    rd(A_STS, 32'h0, "R4 write restarts");
    ticks(1);
    rd(A_STS, 32'h1, "R4 after restart");
    rd(A_PIT, 32'd4, "R4 readback");
    wr(A_PIT, 32'd0);
    ticks(20);
    rd(A_STS, 32'h0, "R4 zero disables");
    // mask and interrupt
    wr(A_PIT, 32'd1);
    ticks(1);
    @(negedge clk);
    check("R7 masked pending no irq", {31'h0, irq}, 32'h0);
    wr(A_IEN, 32'h1);
    @(negedge clk);
    check("R7 enabled pending irq", {31'h0, irq}, 32'h1);
    rd(A_STS, 32'h1, "R5 pending periodic");
    @(negedge clk);
    check("R7 irq drops after read", {31'h0, irq}, 32'h0);
    wr(A_IEN, 32'h8);
    rd(A_IMK, 32'h9, "R6 zero bits keep mask");
    wr(A_IDS, 32'h1);
    rd(A_IMK, 32'h8, "R6 disable clears");
    ticks(1);
    @(negedge clk);
    check("R7 disabled event no irq", {31'h0, irq}, 32'h0);
    rd(A_STS, 32'h1, "R6 event still latched");
    // event in the same cycle as a status read
    @(negedge clk); rd_en = 1'b1; tick_en = 1'b1; addr = A_STS;
    exp_q.push_back(32'h0); tag_q.push_back("R8 coincident read");
    @(negedge clk); rd_en = 1'b0; tick_en = 1'b0;
    rd(A_STS, 32'h1, "R8 event kept");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule